// File: doc/BRIEF.md
# Byte-Wide I/O Port with Sequenced Bit Commands

This block is an 8-bit general-purpose I/O port. Each pin has a direction bit, an output latch bit and a two-stage input synchroniser. A small register bus can write or read the direction register, write the output latch as a whole byte, read the port byte, and issue single-bit set, clear and invert commands. Bits in output mode drive their latch value. Bits in input mode release their driver, and a read returns the synchronised pin level for them.

A bit command is not an atomic update of one latch bit. The sequencer first reads the port byte as a normal read would. It then changes only the addressed bit. Finally it writes the whole byte back into the output latch. As a result, every input-mode bit of the latch is overwritten with the level currently seen on its pin. Software that later turns such a pin into an output must first rewrite the latch, or the pin will drive whatever level the earlier bit command left there. While the sequence runs the bus is stalled: `bus_ready` stays low until it ends.

`rst_n` is asynchronous active-low. It is expected to be released in step with `clk` by the surrounding reset logic.

Top module: `gpio_rmw_port`

## Requirements
- R1: After reset all direction bits are 1 (input), the output latch is 00h, every `pin_oe` bit is 0, `busy` is 0 and `bus_ready` is 1.
- R2: A direction bit of 1 clears the matching `pin_oe` bit. A direction bit of 0 sets it. `pin_out` always carries the output latch.
- R3: An accepted data write (`bus_op` = 0) loads all eight latch bits from `bus_wdata` whatever the direction bits are, visible on `pin_out` the cycle after acceptance.
- R4: An accepted data read (`bus_op` = 1) raises `rd_valid` for one cycle after acceptance. For each bit, `rd_data` holds the synchronised pin level if the bit is an input and the latch bit if it is an output.
- R5: Each pin passes through two flops before it is used. A pin change made just before a read is accepted is not seen by that read, and it is seen once two further clock edges have passed.
- R6: A bit command (`bus_op` 4, 5 or 6, index in `bus_bit`) steps through read, modify and write states. `busy` is high for exactly three cycles, and the latch changes on the third clock edge after acceptance.
- R7: Opcode 4 sets the indexed bit, opcode 5 clears it and opcode 6 inverts it. No other bit of the byte that was read is changed.
- R8: A bit command writes the full read byte back, so each input-mode latch bit takes its pin level. Example: direction FEh, latch 00h, pins FFh, set bit 0 gives latch FFh.
- R9: While `busy` is high `bus_ready` is low, and a pending request has no effect until it is accepted after the sequence ends.
- R10: Opcode 2 writes the direction register and opcode 3 reads it back on `rd_data`. Opcode 7 is ignored: latch, direction and `rd_valid` are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Request present |
| bus_op | input | 3 | Operation code (see R3, R4, R6, R7, R10) |
| bus_wdata | input | 8 | Write data for data and direction writes |
| bus_bit | input | 3 | Bit index for bit commands |
| bus_ready | output | 1 | Request accepted on this edge when high with `bus_valid` |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 8 | Read result |
| busy | output | 1 | Bit command sequence running |
| pin_in | input | 8 | Pin levels |
| pin_out | output | 8 | Output latch driven to pins |
| pin_oe | output | 8 | Per-pin driver enable |

## Verification
The bench sweeps all 256 direction patterns. For each one it loads a random latch and random pin levels, then runs a bit command on every index with the opcode rotating. This separates a correct byte-wide write-back, where input bits follow their pins, from a per-bit update, where input bits keep their latch. Data reads after each command check the per-bit choice between pin and latch. Directed cases cover the 00h/FEh corner, the synchroniser delay, a request stalled behind a running command, and the ignored opcode.

// File: rtl/gpio_rmw_pkg.sv
package gpio_rmw_pkg;

  typedef enum logic [2:0] {
    OP_DWR  = 3'd0,
    OP_DRD  = 3'd1,
    OP_MWR  = 3'd2,
    OP_MRD  = 3'd3,
    OP_BSET = 3'd4,
    OP_BCLR = 3'd5,
    OP_BINV = 3'd6,
    OP_NONE = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_READ   = 2'd1,
    ST_MODIFY = 2'd2,
    ST_WRITE  = 2'd3
  } seq_state_e;

endpackage

// File: rtl/gpio_rmw_sync.sv
module gpio_rmw_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_async,
  output logic [W-1:0] pin_sync
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic meta_q;
    logic stab_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q <= 1'b0;
        stab_q <= 1'b0;
      end else begin
        meta_q <= pin_async[i];
        stab_q <= meta_q;
      end
    end
    assign pin_sync[i] = stab_q;
  end

endmodule

// File: rtl/gpio_rmw_regs.sv
module gpio_rmw_regs #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         lat_we,
  input  logic [W-1:0] lat_wd,
  input  logic         dir_we,
  input  logic [W-1:0] dir_wd,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] dir_q
);

  logic [W-1:0] lat_nxt;
  logic [W-1:0] dir_nxt;

  always_comb begin
    lat_nxt = lat_q;
    dir_nxt = dir_q;
    if (lat_we) lat_nxt = lat_wd;
    if (dir_we) dir_nxt = dir_wd;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
      dir_q <= '1;
    end else begin
      lat_q <= lat_nxt;
      dir_q <= dir_nxt;
    end
  end

endmodule

// File: rtl/gpio_rmw_seq.sv
module gpio_rmw_seq
  import gpio_rmw_pkg::*;
#(
  parameter int W     = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  op_e              op,
  input  logic [IDX_W-1:0] idx,
  input  logic [W-1:0]     rd_val,
  output logic             busy,
  output logic             wr_en,
  output logic [W-1:0]     wr_data
);

  seq_state_e       state_q, state_nxt;
  op_e              op_q, op_nxt;
  logic [IDX_W-1:0] idx_q, idx_nxt;
  logic [W-1:0]     work_q, work_nxt;
  logic [W-1:0]     mask;

  assign mask = {{(W-1){1'b0}}, 1'b1} << idx_q;

  always_comb begin
    state_nxt = state_q;
    op_nxt    = op_q;
    idx_nxt   = idx_q;
    work_nxt  = work_q;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          state_nxt = ST_READ;
          op_nxt    = op;
          idx_nxt   = idx;
        end
      end
      ST_READ: begin
        work_nxt  = rd_val;
        state_nxt = ST_MODIFY;
      end
      ST_MODIFY: begin
        case (op_q)
          OP_BSET: work_nxt = work_q | mask;
          OP_BCLR: work_nxt = work_q & ~mask;
          OP_BINV: work_nxt = work_q ^ mask;
          default: work_nxt = work_q;
        endcase
        state_nxt = ST_WRITE;
      end
      default: state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      op_q    <= OP_NONE;
      idx_q   <= '0;
      work_q  <= '0;
    end else begin
      state_q <= state_nxt;
      op_q    <= op_nxt;
      idx_q   <= idx_nxt;
      work_q  <= work_nxt;
    end
  end

  assign busy    = (state_q != ST_IDLE);
  assign wr_en   = (state_q == ST_WRITE);
  assign wr_data = work_q;

  assert_read_to_modify_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_READ |=> state_q == ST_MODIFY);
  assert_modify_to_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_MODIFY |=> state_q == ST_WRITE);
  assert_write_to_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_WRITE |=> state_q == ST_IDLE);
  assert_single_bit_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state_q == ST_MODIFY |=> $countones(work_q ^ $past(work_q)) <= 1);

endmodule

// File: rtl/gpio_rmw_port.sv
module gpio_rmw_port
  import gpio_rmw_pkg::*;
#(
  parameter  int W     = 8,
  localparam int IDX_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic [2:0]       bus_op,
  input  logic [W-1:0]     bus_wdata,
  input  logic [IDX_W-1:0] bus_bit,
  output logic             bus_ready,
  output logic             rd_valid,
  output logic [W-1:0]     rd_data,
  output logic             busy,
  input  logic [W-1:0]     pin_in,
  output logic [W-1:0]     pin_out,
  output logic [W-1:0]     pin_oe
);

  op_e          op_in;
  logic         accept;
  logic         is_bitop;
  logic         is_read;
  logic [W-1:0] pin_s;
  logic [W-1:0] lat_q;
  logic [W-1:0] dir_q;
  logic [W-1:0] port_val;
  logic         seq_busy;
  logic         seq_wr_en;
  logic [W-1:0] seq_wr_data;
  logic         lat_we;
  logic [W-1:0] lat_wd;
  logic         dir_we;
  logic         rdv_q, rdv_nxt;
  logic [W-1:0] rdd_q, rdd_nxt;

  assign op_in     = op_e'(bus_op);
  assign bus_ready = ~seq_busy;
  assign accept    = bus_valid & bus_ready;
  assign is_bitop  = (op_in == OP_BSET) || (op_in == OP_BCLR) || (op_in == OP_BINV);
  assign is_read   = (op_in == OP_DRD) || (op_in == OP_MRD);

  gpio_rmw_sync #(.W(W)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_async (pin_in),
    .pin_sync  (pin_s)
  );

  assign port_val = (dir_q & pin_s) | (~dir_q & lat_q);

  gpio_rmw_seq #(.W(W), .IDX_W(IDX_W)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (accept & is_bitop),
    .op      (op_in),
    .idx     (bus_bit),
    .rd_val  (port_val),
    .busy    (seq_busy),
    .wr_en   (seq_wr_en),
    .wr_data (seq_wr_data)
  );

  assign lat_we = (accept && op_in == OP_DWR) || seq_wr_en;
  assign lat_wd = seq_wr_en ? seq_wr_data : bus_wdata;
  assign dir_we = accept && op_in == OP_MWR;

  gpio_rmw_regs #(.W(W)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .lat_we (lat_we),
    .lat_wd (lat_wd),
    .dir_we (dir_we),
    .dir_wd (bus_wdata),
    .lat_q  (lat_q),
    .dir_q  (dir_q)
  );

  always_comb begin
    rdv_nxt = accept & is_read;
    rdd_nxt = rdd_q;
    if (accept && is_read) rdd_nxt = (op_in == OP_MRD) ? dir_q : port_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdd_q <= '0;
    end else begin
      rdv_q <= rdv_nxt;
      rdd_q <= rdd_nxt;
    end
  end

  assign rd_valid = rdv_q;
  assign rd_data  = rdd_q;
  assign busy     = seq_busy;
  assign pin_out  = lat_q;
  assign pin_oe   = ~dir_q;

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_in == OP_DWR |=> pin_out == $past(bus_wdata));
  assert_read_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_in == OP_DRD |=> rd_valid);
  assert_dir_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(pin_oe));
  assert_ignore_nop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    accept && op_in == OP_NONE |=> $stable(pin_out) && $stable(pin_oe) && !rd_valid);

endmodule

// File: tb/gpio_rmw_port_bench.sv
module gpio_rmw_port_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       bus_valid;
  logic [2:0] bus_op;
  logic [7:0] bus_wdata;
  logic [2:0] bus_bit;
  logic       bus_ready;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       busy;
  logic [7:0] pin_in;
  logic [7:0] pin_out;
  logic [7:0] pin_oe;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;
  int busy_cycles;

  logic [7:0] m_lat, m_dir, m_pin;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_rmw_port u_gpio_rmw_port (
    .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_op(bus_op),
    .bus_wdata(bus_wdata), .bus_bit(bus_bit), .bus_ready(bus_ready),
    .rd_valid(rd_valid), .rd_data(rd_data), .busy(busy),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] port_model();
    return (m_dir & m_pin) | (~m_dir & m_lat);
  endfunction

  // called at a negedge; returns at the negedge after acceptance,
  // or after the bit sequence has ended
  task automatic do_op(input logic [2:0] op, input logic [7:0] wd, input logic [2:0] bi);
    while (!bus_ready) @(negedge clk);
    bus_valid = 1'b1; bus_op = op; bus_wdata = wd; bus_bit = bi;
    @(posedge clk);
    @(negedge clk);
    bus_valid = 1'b0; bus_op = 3'd7;
    busy_cycles = 0;
    while (busy) begin
      busy_cycles++;
      @(negedge clk);
    end
  endtask

  task automatic set_pins(input logic [7:0] p);
    pin_in = p; m_pin = p;
    repeat (3) @(negedge clk);
  endtask

  task automatic bit_model(input logic [2:0] op, input logic [2:0] bi);
    logic [7:0] v;
    v = port_model();
    case (op)
      3'd4: v[bi] = 1'b1;
      3'd5: v[bi] = 1'b0;
      default: v[bi] = ~v[bi];
    endcase
    m_lat = v;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; bus_valid = 1'b0; bus_op = 3'd7; bus_wdata = '0; bus_bit = '0;
    pin_in = 8'h00; m_pin = 8'h00; m_lat = 8'h00; m_dir = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 8'h00);
    check("R1 pin_out", pin_out, 8'h00);
    check("R1 busy/ready", {6'd0, busy, bus_ready}, 8'h01);
    do_op(3'd3, 8'h00, 3'd0);
    check("R10 dir readback after reset R1", rd_data, 8'hFF);

    // R8 corner case: dir FEh, latch 00h, pins FFh, set bit 0
    set_pins(8'hFF);
    do_op(3'd2, 8'hFE, 3'd0); m_dir = 8'hFE;
    check("R2 pin_oe", pin_oe, 8'h01);
    do_op(3'd0, 8'h00, 3'd0); m_lat = 8'h00;
    check("R3 latch write", pin_out, 8'h00);
    do_op(3'd1, 8'h00, 3'd0);
    check("R4 read mixes pins and latch", rd_data, 8'hFE);
    do_op(3'd4, 8'h00, 3'd0);
    check("R6 busy cycles", 8'(busy_cycles), 8'd3);
    check("R8 latch after set bit0", pin_out, 8'hFF);
    do_op(3'd2, 8'h00, 3'd0); m_dir = 8'h00; m_lat = 8'hFF;
    check("R8 stale latch now driven", pin_out & pin_oe, 8'hFF);

    // R5 synchroniser delay
    do_op(3'd2, 8'hFF, 3'd0); m_dir = 8'hFF;
    set_pins(8'h00);
    pin_in = 8'hA5;
    do_op(3'd1, 8'h00, 3'd0);
    check("R5 read before sync", rd_data, 8'h00);
    @(negedge clk);
    do_op(3'd1, 8'h00, 3'd0);
    check("R5 read after two edges", rd_data, 8'hA5);
    m_pin = 8'hA5;

    // R9 stalled write behind a bit command
    do_op(3'd2, 8'h00, 3'd0); m_dir = 8'h00;
    do_op(3'd0, 8'h00, 3'd0); m_lat = 8'h00;
    bus_valid = 1'b1; bus_op = 3'd4; bus_bit = 3'd3;
    @(posedge clk); @(negedge clk);
    bus_op = 3'd0; bus_wdata = 8'hA5;
    check("R9 ready low while busy", {7'd0, bus_ready}, 8'h00);
    while (!bus_ready) @(negedge clk);
    check("R9 stalled write not applied", pin_out, 8'h08);
    @(posedge clk); @(negedge clk);
    bus_valid = 1'b0; bus_op = 3'd7;
    check("R9 write applied after stall", pin_out, 8'hA5);
    m_lat = 8'hA5;

    // R10 ignored opcode
    do_op(3'd7, 8'h5A, 3'd2);
    check("R10 nop latch", pin_out, 8'hA5);
    check("R10 nop oe", pin_oe, 8'hFF);
    check("R10 nop rd_valid", {7'd0, rd_valid}, 8'h00);

    // sweep over every direction pattern, every bit, rotating opcodes
    for (int m = 0; m < 256; m++) begin
      do_op(3'd2, 8'(m), 3'd0); m_dir = 8'(m);
      check("R2 oe follows dir", pin_oe, ~m_dir);
      m_lat = 8'($urandom());
      do_op(3'd0, m_lat, 3'd0);
      check("R3 sweep write", pin_out, m_lat);
      for (int b = 0; b < 8; b++) begin
        logic [2:0] op;
        op = 3'(4 + ((m + b) % 3));
        set_pins(8'($urandom()));
        do_op(op, 8'h00, 3'(b));
        bit_model(op, 3'(b));
        check("R7 R8 latch after bit command", pin_out, m_lat);
        do_op(3'd1, 8'h00, 3'd0);
        check("R4 sweep read", rd_data, port_model());
      end
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule